// File: doc/BRIEF.md
# AXI4-Lite Shared Mailbox RAM

This block is a small byte memory that two agents share. A host processor reaches it over an AXI4-Lite slave port with 32-bit data. An embedded controller reaches the same storage one byte at a time. The controller first latches a byte address. It can then read the addressed byte or store a byte there with a single-cycle write strobe. Both sides run on one clock and share one synchronous active-low reset.

The host sees the memory as 32-bit words in little-endian order. Byte address 4k holds bits 7:0 of word k, and byte address 4k+3 holds bits 31:24. The memory size is a parameter: a power of two from 16 to 256 bytes. Both sides use a byte address of log2(size) bits. A typical use is a mailbox. One side deposits a message or a flag, and the other side polls for it and clears it. The layout of the mailbox contents is left to software.

Top module: `mbox_ram`

## Requirements
- R1: A host word written with all four strobes set is stored little-endian. The controller then reads `w_data[7:0]` at byte address 4k and `w_data[31:24]` at byte address 4k+3, and a host read returns the same word.
- R2: A host write updates only the bytes whose `w_strb` bit is set. Bit i of `w_strb` covers `w_data[8i+7:8i]` and byte address 4k+i. All other bytes keep their values.
- R3: The two low bits of `aw_addr` and `ar_addr` have no effect. Any address inside a word selects that aligned word.
- R4: `b_resp` and `r_resp` are always 2'b00 (OKAY) while their valid is high.
- R5: The AW and W handshakes may complete in either order or in the same cycle. `b_valid` rises only after both have completed, and it stays high until a cycle with `b_ready` high. While `b_valid` is high, `aw_ready` and `w_ready` are low.
- R6: `r_valid` is high in the cycle after an AR handshake. `r_data` then holds the addressed word and stays stable until a cycle with `r_ready` high. `ar_ready` is low while `r_valid` is high.
- R7: A clock edge with `ctl_addr_ld` high latches `ctl_addr`. One edge later, `ctl_rd_byte` holds the byte stored at that address, and it keeps following that byte every cycle.
- R8: A clock edge with `ctl_wr_stb` high stores `ctl_wr_byte` at the latched controller address. The host then sees the new byte.
- R9: When the host write commit and a controller strobe hit the same byte at the same edge, the host byte is kept. A controller byte in a lane the host does not strobe is still stored in that same cycle.
- R10: While `rst_n` is low, `aw_ready`, `w_ready` and `ar_ready` are low, and after a reset edge `b_valid` and `r_valid` are low. Memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous reset, active low |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_addr | input | AW | Write byte address, AW = log2(MEM_BYTES) |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | 32 | Write data |
| w_strb | input | 4 | Byte strobes, bit i covers w_data[8i+7:8i] |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_resp | output | 2 | Write response, always OKAY |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_addr | input | AW | Read byte address |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_data | output | 32 | Read word |
| r_resp | output | 2 | Read response, always OKAY |
| ctl_addr_ld | input | 1 | Controller address load strobe |
| ctl_addr | input | AW | Controller byte address to latch |
| ctl_wr_stb | input | 1 | Controller write strobe |
| ctl_wr_byte | input | 8 | Controller byte to store on the strobe |
| ctl_rd_byte | output | 8 | Byte at the latched controller address |

## Verification
The assertions watch the handshake rules on every cycle. They check that responses are always OKAY, that `b_valid` and `r_valid` stay held until accepted, that `r_data` stays stable while it waits, that readies are low while a response is pending or reset is low, and that `r_valid` follows an AR handshake by one cycle. Only the bench scenarios can show data correctness. That covers the little-endian lane mapping, strobe masking, the ignored low address bits, controller reads and writes through the latched address, the host-wins rule on a same-byte collision next to a non-colliding controller write, and memory retention across reset.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LANES   = 4;
  localparam int unsigned WORD_W  = BYTE_W * LANES;
  localparam int unsigned RESP_W  = 2;
  localparam logic [RESP_W-1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/mbox_byte_store.sv
// Byte-granular storage with a host word write port, a controller byte
// write port, a host word read tap and a controller byte read tap.
module mbox_byte_store #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          hw_en,
  input  logic [AW-3:0]                 hw_row,
  input  logic [mbox_pkg::LANES-1:0]    hw_strb,
  input  logic [mbox_pkg::WORD_W-1:0]   hw_data,
  input  logic                          cw_en,
  input  logic [AW-1:0]                 cw_addr,
  input  logic [mbox_pkg::BYTE_W-1:0]   cw_byte,
  input  logic [AW-3:0]                 hr_row,
  output logic [mbox_pkg::WORD_W-1:0]   hr_word,
  input  logic [AW-1:0]                 cr_addr,
  output logic [mbox_pkg::BYTE_W-1:0]   cr_byte
);
  import mbox_pkg::*;
  localparam int unsigned RW = AW - 2;

  logic [BYTE_W-1:0] mem [DEPTH];

  // One register per byte: the host port has priority over the controller.
  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam int unsigned LANE = g % LANES;
    localparam int unsigned ROW  = g / LANES;
    logic host_hit, ctl_hit;
    assign host_hit = hw_en && (hw_row == RW'(ROW)) && hw_strb[LANE];
    assign ctl_hit  = cw_en && (cw_addr == AW'(g));
    always_ff @(posedge clk) begin
      if (host_hit)
        mem[g] <= hw_data[BYTE_W*LANE +: BYTE_W];
      else if (ctl_hit)
        mem[g] <= cw_byte;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd_lane
    assign hr_word[BYTE_W*l +: BYTE_W] = mem[{hr_row, 2'(l)}];
  end

  assign cr_byte = mem[cr_addr];
endmodule

// File: rtl/mbox_wr_ctrl.sv
// Joins the AW and W channels in either order, commits one word, answers on B.
module mbox_wr_ctrl #(
  parameter int unsigned AW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          aw_valid,
  output logic                          aw_ready,
  input  logic [AW-1:0]                 aw_addr,
  input  logic                          w_valid,
  output logic                          w_ready,
  input  logic [mbox_pkg::WORD_W-1:0]   w_data,
  input  logic [mbox_pkg::LANES-1:0]    w_strb,
  output logic                          b_valid,
  input  logic                          b_ready,
  output logic [mbox_pkg::RESP_W-1:0]   b_resp,
  output logic                          hw_en,
  output logic [AW-3:0]                 hw_row,
  output logic [mbox_pkg::LANES-1:0]    hw_strb,
  output logic [mbox_pkg::WORD_W-1:0]   hw_data
);
  import mbox_pkg::*;

  logic                aw_got, w_got, bv_q;
  logic [AW-3:0]       row_q;
  logic [WORD_W-1:0]   data_q;
  logic [LANES-1:0]    strb_q;
  logic                aw_fire, w_fire, commit;

  assign aw_ready = rst_n && !aw_got && !bv_q;
  assign w_ready  = rst_n && !w_got  && !bv_q;
  assign aw_fire  = aw_valid && aw_ready;
  assign w_fire   = w_valid  && w_ready;
  assign commit   = aw_got && w_got;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_got <= 1'b0;
      w_got  <= 1'b0;
      bv_q   <= 1'b0;
    end else begin
      if (aw_fire) aw_got <= 1'b1;
      if (w_fire)  w_got  <= 1'b1;
      if (commit) begin
        aw_got <= 1'b0;
        w_got  <= 1'b0;
        bv_q   <= 1'b1;
      end else if (bv_q && b_ready) begin
        bv_q   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (aw_fire) row_q <= aw_addr[AW-1:2];
    if (w_fire) begin
      data_q <= w_data;
      strb_q <= w_strb;
    end
  end

  assign hw_en   = commit;
  assign hw_row  = row_q;
  assign hw_strb = strb_q;
  assign hw_data = data_q;
  assign b_valid = bv_q;
  assign b_resp  = RESP_OKAY;
endmodule

// File: rtl/mbox_rd_ctrl.sv
// Accepts one AR at a time and holds the registered word until R completes.
module mbox_rd_ctrl #(
  parameter int unsigned AW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ar_valid,
  output logic                          ar_ready,
  input  logic [AW-1:0]                 ar_addr,
  output logic                          r_valid,
  input  logic                          r_ready,
  output logic [mbox_pkg::WORD_W-1:0]   r_data,
  output logic [mbox_pkg::RESP_W-1:0]   r_resp,
  output logic [AW-3:0]                 hr_row,
  input  logic [mbox_pkg::WORD_W-1:0]   hr_word
);
  import mbox_pkg::*;

  logic              rv_q;
  logic [WORD_W-1:0] rdata_q;
  logic              ar_fire;

  assign ar_ready = rst_n && !rv_q;
  assign ar_fire  = ar_valid && ar_ready;
  assign hr_row   = ar_addr[AW-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n)
      rv_q <= 1'b0;
    else if (ar_fire)
      rv_q <= 1'b1;
    else if (rv_q && r_ready)
      rv_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (ar_fire) rdata_q <= hr_word;
  end

  assign r_valid = rv_q;
  assign r_data  = rdata_q;
  assign r_resp  = RESP_OKAY;
endmodule

// File: rtl/mbox_ctl_port.sv
// Controller side: latched byte address and a registered read byte.
module mbox_ctl_port #(
  parameter int unsigned AW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld,
  input  logic [AW-1:0]                 addr_in,
  output logic [AW-1:0]                 addr_q,
  input  logic [mbox_pkg::BYTE_W-1:0]   cr_byte,
  output logic [mbox_pkg::BYTE_W-1:0]   rd_byte
);
  import mbox_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)
      addr_q <= '0;
    else if (ld)
      addr_q <= addr_in;
  end

  always_ff @(posedge clk) begin
    rd_byte <= cr_byte;
  end
endmodule

// File: rtl/mbox_ram.sv
module mbox_ram #(
  parameter int unsigned MEM_BYTES = 256,
  localparam int unsigned AW = $clog2(MEM_BYTES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          aw_valid,
  output logic                          aw_ready,
  input  logic [AW-1:0]                 aw_addr,
  input  logic                          w_valid,
  output logic                          w_ready,
  input  logic [31:0]                   w_data,
  input  logic [3:0]                    w_strb,
  output logic                          b_valid,
  input  logic                          b_ready,
  output logic [1:0]                    b_resp,
  input  logic                          ar_valid,
  output logic                          ar_ready,
  input  logic [AW-1:0]                 ar_addr,
  output logic                          r_valid,
  input  logic                          r_ready,
  output logic [31:0]                   r_data,
  output logic [1:0]                    r_resp,
  input  logic                          ctl_addr_ld,
  input  logic [AW-1:0]                 ctl_addr,
  input  logic                          ctl_wr_stb,
  input  logic [7:0]                    ctl_wr_byte,
  output logic [7:0]                    ctl_rd_byte
);
  import mbox_pkg::*;

  if ((MEM_BYTES < 16) || (MEM_BYTES > 256) || ((MEM_BYTES & (MEM_BYTES - 1)) != 0)) begin : g_bad_size
    $error("mbox_ram: MEM_BYTES must be a power of two from 16 to 256");
  end

  logic              hw_en;
  logic [AW-3:0]     hw_row, hr_row;
  logic [LANES-1:0]  hw_strb;
  logic [WORD_W-1:0] hw_data, hr_word;
  logic [AW-1:0]     ctl_addr_q;
  logic [BYTE_W-1:0] cr_byte;

  mbox_wr_ctrl #(.AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
    .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
    .hw_en(hw_en), .hw_row(hw_row), .hw_strb(hw_strb), .hw_data(hw_data)
  );

  mbox_rd_ctrl #(.AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
    .hr_row(hr_row), .hr_word(hr_word)
  );

  mbox_ctl_port #(.AW(AW)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ld(ctl_addr_ld), .addr_in(ctl_addr), .addr_q(ctl_addr_q),
    .cr_byte(cr_byte), .rd_byte(ctl_rd_byte)
  );

  mbox_byte_store #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
    .clk(clk),
    .hw_en(hw_en), .hw_row(hw_row), .hw_strb(hw_strb), .hw_data(hw_data),
    .cw_en(ctl_wr_stb), .cw_addr(ctl_addr_q), .cw_byte(ctl_wr_byte),
    .hr_row(hr_row), .hr_word(hr_word),
    .cr_addr(ctl_addr_q), .cr_byte(cr_byte)
  );
endmodule

// File: rtl/mbox_ram_chk.sv
module mbox_ram_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          aw_valid,
  input logic          aw_ready,
  input logic          w_valid,
  input logic          w_ready,
  input logic          b_valid,
  input logic          b_ready,
  input logic [1:0]    b_resp,
  input logic          ar_valid,
  input logic          ar_ready,
  input logic          r_valid,
  input logic          r_ready,
  input logic [31:0]   r_data,
  input logic [1:0]    r_resp
);
  assert_bresp_okay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> b_resp == 2'b00);
  assert_rresp_okay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> r_resp == 2'b00);
  assert_b_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> b_valid);
  assert_wr_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> (!aw_ready && !w_ready));
  assert_r_after_ar_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready) |=> r_valid);
  assert_r_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data)));
  assert_ar_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> !ar_ready);
  assert_ready_low_R10: assert property (@(posedge clk)
    !rst_n |-> (!aw_ready && !w_ready && !ar_ready));
  assert_valid_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (!b_valid && !r_valid));
endmodule

bind mbox_ram mbox_ram_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_mbox_ram.sv
`timescale 1ns/1ps
module sim_mbox_ram;
  localparam int unsigned N  = 256;
  localparam int unsigned AW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aw_valid = 0, w_valid = 0, b_ready = 0, ar_valid = 0, r_ready = 0;
  logic [AW-1:0] aw_addr = '0, ar_addr = '0, ctl_addr = '0;
  logic [31:0] w_data = '0;
  logic [3:0]  w_strb = '0;
  logic ctl_addr_ld = 0, ctl_wr_stb = 0;
  logic [7:0] ctl_wr_byte = '0;
  logic aw_ready, w_ready, b_valid, ar_ready, r_valid;
  logic [1:0] b_resp, r_resp;
  logic [31:0] r_data;
  logic [7:0] ctl_rd_byte;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] ref_mem [N];
  logic [AW-1:0] ctl_cur = '0;

  always #10 clk = ~clk;

  mbox_ram #(.MEM_BYTES(N)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
    logic [AW-1:0] b = {a[AW-1:2], 2'b00};
    return {ref_mem[b+3], ref_mem[b+2], ref_mem[b+1], ref_mem[b]};
  endfunction

  task automatic send_aw(input logic [AW-1:0] a);
    logic rdy;
    aw_addr = a; aw_valid = 1;
    do begin #1 rdy = aw_ready; @(negedge clk); end while (!rdy);
    aw_valid = 0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] s);
    logic rdy;
    w_data = d; w_strb = s; w_valid = 1;
    do begin #1 rdy = w_ready; @(negedge clk); end while (!rdy);
    w_valid = 0;
  endtask

  task automatic host_write(input logic [AW-1:0] a, input logic [31:0] d,
                            input logic [3:0] s, input int order);
    int n;
    int hold;
    case (order)
      0: fork send_aw(a); send_w(d, s); join
      1: begin send_aw(a); repeat (2) @(negedge clk); chk("R5 no B before W", b_valid, 0); send_w(d, s); end
      default: begin send_w(d, s); repeat (2) @(negedge clk); chk("R5 no B before AW", b_valid, 0); send_aw(a); end
    endcase
    n = 0;
    while (!b_valid && n < 10) begin @(negedge clk); n++; end
    chk("R5 b_valid", b_valid, 1);
    chk("R4 b_resp", b_resp, 0);
    chk("R5 aw_ready low", aw_ready, 0);
    hold = $urandom % 3;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R5 b held", b_valid, 1);
    end
    b_ready = 1; @(negedge clk); b_ready = 0;
    chk("R5 b cleared", b_valid, 0);
    for (int l = 0; l < 4; l++)
      if (s[l]) ref_mem[{a[AW-1:2], 2'(l)}] = d[8*l +: 8];
  endtask

  task automatic host_read(input logic [AW-1:0] a, input string req);
    logic rdy;
    logic [31:0] exp, first;
    int hold;
    exp = exp_word(a);
    ar_addr = a; ar_valid = 1;
    do begin #1 rdy = ar_ready; @(negedge clk); end while (!rdy);
    ar_valid = 0;
    chk("R6 r_valid next cycle", r_valid, 1);
    chk("R6 ar_ready low", ar_ready, 0);
    chk(req, r_data, exp);
    chk("R4 r_resp", r_resp, 0);
    first = r_data;
    hold = $urandom % 3;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R6 r held", {r_valid, 31'(0)} | (r_data ^ first), {1'b1, 31'(0)});
    end
    r_ready = 1; @(negedge clk); r_ready = 0;
    chk("R6 r cleared", r_valid, 0);
  endtask

  task automatic ctl_load(input logic [AW-1:0] a);
    ctl_addr = a; ctl_addr_ld = 1;
    @(negedge clk); ctl_addr_ld = 0;
    ctl_cur = a;
  endtask

  task automatic ctl_read(input string req);
    @(negedge clk);
    chk(req, ctl_rd_byte, ref_mem[ctl_cur]);
  endtask

  task automatic ctl_write(input logic [7:0] b);
    ctl_wr_byte = b; ctl_wr_stb = 1;
    @(negedge clk); ctl_wr_stb = 0;
    ref_mem[ctl_cur] = b;
  endtask

  // Host commit and controller strobe land on the same edge.
  task automatic collide(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s,
                         input logic [AW-1:0] c, input logic [7:0] cb);
    ctl_load(c);
    @(negedge clk);
    aw_addr = a; aw_valid = 1; w_data = d; w_strb = s; w_valid = 1;
    @(negedge clk);
    aw_valid = 0; w_valid = 0;
    ctl_wr_byte = cb; ctl_wr_stb = 1;
    @(negedge clk);
    ctl_wr_stb = 0;
    chk("R9 b_valid after commit", b_valid, 1);
    b_ready = 1; @(negedge clk); b_ready = 0;
    ref_mem[c] = cb;
    for (int l = 0; l < 4; l++)
      if (s[l]) ref_mem[{a[AW-1:2], 2'(l)}] = d[8*l +: 8];
    ctl_read("R9 controller view");
    host_read(a, "R9 host view");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 b_valid in reset", b_valid, 0);
    chk("R10 r_valid in reset", r_valid, 0);
    chk("R10 readies in reset", {aw_ready, w_ready, ar_ready}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    chk("R10 readies after reset", {aw_ready, w_ready, ar_ready}, 3'b111);

    for (int k = 0; k < N / 4; k++)
      host_write(AW'(4 * k), $urandom, 4'hF, k % 3);

    // R1 little-endian lanes
    host_write(AW'(8), 32'h4433_2211, 4'hF, 0);
    ctl_load(AW'(8));  ctl_read("R1 low byte");
    chk("R1 byte 8 is 11", ctl_rd_byte, 8'h11);
    ctl_load(AW'(11)); ctl_read("R1 high byte");
    chk("R1 byte 11 is 44", ctl_rd_byte, 8'h44);
    host_read(AW'(8), "R1 word");
    // R2 strobes
    host_write(AW'(8), 32'hAABB_CCDD, 4'b0101, 1);
    host_read(AW'(8), "R2 masked word");
    chk("R2 merged word", r_data, 32'h44BB_22DD);
    // R3 low address bits ignored
    host_read(AW'(11), "R3 unaligned read");
    host_write(AW'(18), 32'h0102_0304, 4'hF, 2);
    host_read(AW'(16), "R3 unaligned write");
    // R7 / R8 controller side
    ctl_load(AW'(33));
    ctl_write(8'h5A);
    ctl_read("R7 read after write");
    host_read(AW'(32), "R8 host sees controller byte");
    chk("R8 lane1", r_data[15:8], 8'h5A);
    // R9 collisions
    collide(AW'(40), 32'hC3C2_C1C0, 4'b0100, AW'(42), 8'hEE);
    chk("R9 host wins byte 42", r_data[23:16], 8'hC2);
    collide(AW'(44), 32'hD3D2_D1D0, 4'b0001, AW'(47), 8'h77);
    chk("R9 controller lane kept", r_data[31:24], 8'h77);
    chk("R9 host lane kept", r_data[7:0], 8'hD0);

    // Random mix
    for (int it = 0; it < 250; it++) begin
      case ($urandom % 4)
        0: host_write(AW'($urandom), $urandom, 4'($urandom), $urandom % 3);
        1: host_read(AW'($urandom), "R3 random read");
        2: begin ctl_load(AW'($urandom)); ctl_read("R7 random ctl read"); end
        default: begin ctl_load(AW'($urandom)); ctl_write(8'($urandom)); ctl_read("R8 random ctl write"); end
      endcase
    end

    // R10 reset mid-traffic, memory retained
    ar_addr = AW'(8); ar_valid = 1; rst_n = 0;
    #1 chk("R10 readies low under reset", {aw_ready, w_ready, ar_ready}, 3'b000);
    @(negedge clk);
    chk("R10 no valid after reset edge", {b_valid, r_valid}, 2'b00);
    ar_valid = 0; rst_n = 1;
    @(negedge clk);
    host_read(AW'(8), "R10 memory kept");
    host_read(AW'(44), "R10 memory kept 2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule